// File: doc/BRIEF.md
# Keyed Configuration Data Port

This block lets boot firmware exchange small byte streams with the platform through two registers. A halfword write to the selector register picks an entry by a 16-bit key. After that, each byte access to the data register either returns the next byte of the entry or stores one byte into it. A hidden offset advances by one after every accepted byte. Past the end of an entry, reads return zero and the offset holds. When a writable entry has been filled, the block emits a one-cycle completion pulse. The pulse carries the entry's bank and index, so a consumer can pick up the new contents.

Entries sit in two parallel banks, a generic one and an architecture-local one. Key bit 15 picks the bank and key bit 14 grants write permission. Bits 13:0 form the index. Every entry has a length of 0 to 64 bytes and a 64-byte slot in an on-chip byte store. A preload port fills bytes and lengths before or after reset release. A handful of fixed entries come up already populated, with multi-byte integers stored least significant byte first.

Top module: `keyed_cfg_port`

## Requirements
- R1: While reset is held and immediately after it, key 0 is selected with offset 0: `dataRdData` shows byte 0 of generic entry 0 and `doneValid` is low.
- R2: A selector write with `ctlSize` = 1 (halfword) loads the key and clears the offset to 0. Selector writes of any other size (0 byte, 2 word, 3 doubleword) change nothing.
- R3: If key bits 13:0 are 16 or more, the selection becomes the invalid key 16'hFFFF. Every read then returns 0 and no write is stored or completes.
- R4: Key bit 15 = 0 selects the generic bank and 1 selects the architecture-local bank. Both banks use the same index in bits 3:0.
- R5: `dataRdData` presents the byte at the current offset in the same cycle. A byte read advances the offset by one. Once the offset equals the entry length (including length 0), the value is 0 and the offset does not move.
- R6: A byte write is stored at the current offset, and the offset advances, only when key bit 14 is set and the offset is below the entry length. Otherwise it has no effect.
- R7: The write that makes the offset equal to the length sets `doneValid` for exactly the next cycle, with `doneBank`/`doneIdx` naming the entry. The offset returns to 0 at that same edge.
- R8: Data accesses act only with `dataSize` = 0 (byte). Reads or writes of any other size leave offset and contents unchanged.
- R9: The generic bank starts with these fixed entries:
  - Entry 0: the 4 ASCII bytes "KCFG".
  - Entry 1: 16 identifier bytes 0xA0+i.
  - Entry 2: the 16-bit CPU count 4.
  - Entry 3: the 16-bit CPU limit 16.
  - Entry 4: the 64-bit stamp 0x0123456789ABCDEF.
  
  Entries 2 to 4 are little-endian. All other entries have length 0.
- R10: `preByteWr` stores `preData` at (`preBank`, `preIdx`, `preOff`). `preLenWr` sets that entry's length to `preLen`, but a `preLen` above 64 is ignored.
- R11: A halfword selector write in the same cycle as a data access wins. The data access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Selector register write |
| ctlSize | input | 2 | Selector access size (0 byte, 1 half, 2 word, 3 dword) |
| ctlWrData | input | 16 | Key written to the selector |
| dataRdEn | input | 1 | Data register read |
| dataWrEn | input | 1 | Data register write |
| dataSize | input | 2 | Data access size, same encoding |
| dataWrData | input | 8 | Byte written to the data register |
| dataRdData | output | 8 | Byte at the current offset, combinational |
| preByteWr | input | 1 | Preload one byte |
| preLenWr | input | 1 | Preload one entry length |
| preBank | input | 1 | Preload bank |
| preIdx | input | 4 | Preload entry index |
| preOff | input | 6 | Preload byte offset |
| preData | input | 8 | Preload byte |
| preLen | input | 7 | Preload length |
| doneValid | output | 1 | One-cycle completion pulse |
| doneBank | output | 1 | Bank of the completed entry |
| doneIdx | output | 4 | Index of the completed entry |

## Verification
Read data is combinational, so the bench checks it 1 ns after driving the read on a falling edge, before the rising edge that moves the offset. Offset movement is seen on the next access one cycle later. The completion pulse is registered: after a write is driven, the bench idles for one cycle and samples `doneValid`, bank and index on the following falling edge. Selects and preloads take effect at the next rising edge, so the first dependent check is always driven on the falling edge after it.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } kcpSize_e;

  // strobes from control to datapath, at most one data strobe per cycle
  typedef struct packed {
    logic selStb;
    logic rdStb;
    logic wrStb;
  } kcpStrobe_t;

endpackage

// File: rtl/kcp_ctrl.sv
module kcpCtrl
  import kcp_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctlWrEn,
  input  logic [1:0]                 ctlSize,
  input  logic                       dataRdEn,
  input  logic                       dataWrEn,
  input  logic [1:0]                 dataSize,
  input  logic                       selValid,
  input  logic                       selWritable,
  input  logic                       atEnd,
  input  logic                       lastByte,
  input  logic                       selBank,
  input  logic [$clog2(ENTRIES)-1:0] selIdx,
  output kcpStrobe_t                 stb,
  output logic                       doneValid,
  output logic                       doneBank,
  output logic [$clog2(ENTRIES)-1:0] doneIdx
);

  logic selHit;
  logic byteOk;
  logic canMove;

  assign selHit  = ctlWrEn && (ctlSize == SZ_HALF);
  // data access only counts when it is byte wide and not shadowed by a select
  assign byteOk  = (dataSize == SZ_BYTE) && !selHit;
  assign canMove = byteOk && selValid && !atEnd;

  always_comb begin
    stb        = '0;
    stb.selStb = selHit;
    stb.wrStb  = dataWrEn && canMove && selWritable;
    stb.rdStb  = dataRdEn && !dataWrEn && canMove;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneBank  <= 1'b0;
      doneIdx   <= '0;
    end else begin
      doneValid <= stb.wrStb && lastByte;
      if (stb.wrStb && lastByte) begin
        doneBank <= selBank;
        doneIdx  <= selIdx;
      end
    end
  end

endmodule

// File: rtl/kcp_data.sv
module kcpData
  import kcp_pkg::*;
#(
  parameter int          ENTRIES   = 16,
  parameter int          MAX_LEN   = 64,
  parameter int          KEY_W     = 16,
  parameter logic [31:0] SIG       = 32'h4B43_4647,
  parameter logic [15:0] CPU_COUNT = 16'd4,
  parameter logic [15:0] CPU_MAX   = 16'd16,
  parameter logic [63:0] STAMP     = 64'h0123_4567_89AB_CDEF
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  kcpStrobe_t                   stb,
  input  logic [KEY_W-1:0]             keyIn,
  input  logic [7:0]                   wrData,
  input  logic                         preByteWr,
  input  logic                         preLenWr,
  input  logic                         preBank,
  input  logic [$clog2(ENTRIES)-1:0]   preIdx,
  input  logic [$clog2(MAX_LEN)-1:0]   preOff,
  input  logic [7:0]                   preData,
  input  logic [$clog2(MAX_LEN+1)-1:0] preLen,
  output logic [KEY_W-1:0]             selKey,
  output logic [$clog2(MAX_LEN+1)-1:0] selOff,
  output logic                         selValid,
  output logic                         selWritable,
  output logic                         atEnd,
  output logic                         lastByte,
  output logic                         selBank,
  output logic [$clog2(ENTRIES)-1:0]   selIdx,
  output logic [7:0]                   rdData
);

  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int AOFF_W   = $clog2(MAX_LEN);
  localparam int OFF_W    = $clog2(MAX_LEN+1);
  localparam int IDXF_W   = KEY_W - 2;
  localparam int ARCH_BIT = KEY_W - 1;
  localparam int WRCH_BIT = KEY_W - 2;
  localparam int DEPTH    = 2 * ENTRIES * MAX_LEN;
  localparam int ADDR_W   = 1 + IDX_W + AOFF_W;
  localparam logic [IDXF_W-1:0] ENT_LIM = IDXF_W'(ENTRIES);
  localparam logic [OFF_W-1:0]  LEN_LIM = OFF_W'(MAX_LEN);
  localparam logic [KEY_W-1:0]  BAD_KEY = '1;

  function automatic int defaultLen(int bank, int idx);
    if (bank != 0) return 0;
    case (idx)
      0:       return 4;
      1:       return 16;
      2, 3:    return 2;
      4:       return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] defaultByte(int idx, int off);
    case (idx)
      0:       return SIG[8*(3-off) +: 8];
      1:       return 8'(8'hA0 + off);
      2:       return CPU_COUNT[8*off +: 8];
      3:       return CPU_MAX[8*off +: 8];
      4:       return STAMP[8*off +: 8];
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0]        store [DEPTH];
  logic [OFF_W-1:0]  bankLen [2];
  logic [OFF_W-1:0]  selLen;
  logic [IDXF_W-1:0] selField;
  logic [IDXF_W-1:0] keyField;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] preAddr;
  logic [OFF_W:0]    offNext;

  // key and offset registers
  assign keyField = keyIn[IDXF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selKey <= '0;
      selOff <= '0;
    end else if (stb.selStb) begin
      selKey <= (keyField >= ENT_LIM) ? BAD_KEY : keyIn;
      selOff <= '0;
    end else if (stb.wrStb) begin
      selOff <= lastByte ? '0 : offNext[OFF_W-1:0];
    end else if (stb.rdStb) begin
      selOff <= offNext[OFF_W-1:0];
    end
  end

  assign selField    = selKey[IDXF_W-1:0];
  assign selValid    = selField < ENT_LIM;
  assign selWritable = selKey[WRCH_BIT];
  assign selBank     = selKey[ARCH_BIT];
  assign selIdx      = selField[IDX_W-1:0];
  assign selLen      = bankLen[selBank];
  assign offNext     = {1'b0, selOff} + 1'b1;
  assign atEnd       = selOff >= selLen;
  assign lastByte    = offNext == {1'b0, selLen};

  // per-bank length tables
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [OFF_W-1:0] lenTab [ENTRIES];

    initial begin
      for (int e = 0; e < ENTRIES; e++) lenTab[e] = OFF_W'(defaultLen(b, e));
    end

    always_ff @(posedge clk) begin
      if (preLenWr && (preBank == 1'(b)) && (preLen <= LEN_LIM))
        lenTab[preIdx] <= preLen;
    end

    assign bankLen[b] = lenTab[selIdx];
  end

  // byte store: bus write has priority over the preload port
  assign curAddr = {selBank, selIdx, selOff[AOFF_W-1:0]};
  assign preAddr = {preBank, preIdx, preOff};

  initial begin
    for (int a = 0; a < DEPTH; a++) store[a] = 8'h00;
    for (int e = 0; e < ENTRIES; e++)
      for (int o = 0; o < defaultLen(0, e); o++)
        store[e * MAX_LEN + o] = defaultByte(e, o);
  end

  always_ff @(posedge clk) begin
    if (stb.wrStb) store[curAddr] <= wrData;
    else if (preByteWr) store[preAddr] <= preData;
  end

  assign rdData = (selValid && !atEnd) ? store[curAddr] : 8'h00;

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import kcp_pkg::*;
#(
  parameter int          ENTRIES   = 16,
  parameter int          MAX_LEN   = 64,
  parameter int          KEY_W     = 16,
  parameter logic [31:0] SIG       = 32'h4B43_4647,
  parameter logic [15:0] CPU_COUNT = 16'd4,
  parameter logic [15:0] CPU_MAX   = 16'd16,
  parameter logic [63:0] STAMP     = 64'h0123_4567_89AB_CDEF
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ctlWrEn,
  input  logic [1:0]                   ctlSize,
  input  logic [KEY_W-1:0]             ctlWrData,
  input  logic                         dataRdEn,
  input  logic                         dataWrEn,
  input  logic [1:0]                   dataSize,
  input  logic [7:0]                   dataWrData,
  output logic [7:0]                   dataRdData,
  input  logic                         preByteWr,
  input  logic                         preLenWr,
  input  logic                         preBank,
  input  logic [$clog2(ENTRIES)-1:0]   preIdx,
  input  logic [$clog2(MAX_LEN)-1:0]   preOff,
  input  logic [7:0]                   preData,
  input  logic [$clog2(MAX_LEN+1)-1:0] preLen,
  output logic                         doneValid,
  output logic                         doneBank,
  output logic [$clog2(ENTRIES)-1:0]   doneIdx
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int OFF_W = $clog2(MAX_LEN+1);

  kcpStrobe_t       stb;
  logic [KEY_W-1:0] selKey;
  logic [OFF_W-1:0] selOff;
  logic             selValid;
  logic             selWritable;
  logic             atEnd;
  logic             lastByte;
  logic             selBank;
  logic [IDX_W-1:0] selIdx;

  kcpCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlWrEn(ctlWrEn), .ctlSize(ctlSize),
    .dataRdEn(dataRdEn), .dataWrEn(dataWrEn), .dataSize(dataSize),
    .selValid(selValid), .selWritable(selWritable),
    .atEnd(atEnd), .lastByte(lastByte),
    .selBank(selBank), .selIdx(selIdx),
    .stb(stb),
    .doneValid(doneValid), .doneBank(doneBank), .doneIdx(doneIdx)
  );

  kcpData #(
    .ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .KEY_W(KEY_W), .SIG(SIG),
    .CPU_COUNT(CPU_COUNT), .CPU_MAX(CPU_MAX), .STAMP(STAMP)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .keyIn(ctlWrData), .wrData(dataWrData),
    .preByteWr(preByteWr), .preLenWr(preLenWr), .preBank(preBank),
    .preIdx(preIdx), .preOff(preOff), .preData(preData), .preLen(preLen),
    .selKey(selKey), .selOff(selOff), .selValid(selValid),
    .selWritable(selWritable), .atEnd(atEnd), .lastByte(lastByte),
    .selBank(selBank), .selIdx(selIdx), .rdData(dataRdData)
  );

endmodule

// File: rtl/kcp_checker.sv
module kcpChecker #(
  parameter int KEY_W   = 16,
  parameter int MAX_LEN = 64,
  parameter int OFF_W   = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlWrEn,
  input logic [1:0]       ctlSize,
  input logic             dataRdEn,
  input logic             dataWrEn,
  input logic [1:0]       dataSize,
  input logic [7:0]       dataRdData,
  input logic             doneValid,
  input logic [KEY_W-1:0] selKey,
  input logic [OFF_W-1:0] selOff
);

  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(MAX_LEN);

  AST_SELECT_CLEARS_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlSize == 2'd1) |=> (selOff == '0));  // R2

  AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (selKey == '1) |-> (dataRdData == 8'h00));  // R3

  AST_OFFSET_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    selOff <= OFF_MAX);  // R5

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(dataWrEn && dataSize == 2'd0 && !(ctlWrEn && ctlSize == 2'd1)));  // R7

  AST_DONE_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (selOff == '0));  // R7

  AST_WIDE_DATA_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!(ctlWrEn && ctlSize == 2'd1) && dataSize != 2'd0 && (dataRdEn || dataWrEn))
      |=> $stable(selOff));  // R8

endmodule

bind keyed_cfg_port kcpChecker #(
  .KEY_W(KEY_W), .MAX_LEN(MAX_LEN), .OFF_W($clog2(MAX_LEN+1))
) u_chk (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlSize(ctlSize),
  .dataRdEn(dataRdEn), .dataWrEn(dataWrEn), .dataSize(dataSize),
  .dataRdData(dataRdData), .doneValid(doneValid),
  .selKey(selKey), .selOff(selOff)
);

// File: tb/keyed_cfg_port_bench.sv
module keyed_cfg_port_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctlWrEn, dataRdEn, dataWrEn;
  logic [1:0]  ctlSize, dataSize;
  logic [15:0] ctlWrData;
  logic [7:0]  dataWrData, dataRdData;
  logic        preByteWr, preLenWr, preBank;
  logic [3:0]  preIdx;
  logic [5:0]  preOff;
  logic [7:0]  preData;
  logic [6:0]  preLen;
  logic        doneValid, doneBank;
  logic [3:0]  doneIdx;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  keyed_cfg_port u_keyed_cfg_port (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv(input bit cw, input bit [1:0] cs, input bit [15:0] key,
                     input bit rd, input bit wr, input bit [1:0] ds, input bit [7:0] wd);
    ctlWrEn = cw; ctlSize = cs; ctlWrData = key;
    dataRdEn = rd; dataWrEn = wr; dataSize = ds; dataWrData = wd;
    preByteWr = 1'b0; preLenWr = 1'b0;
  endtask

  task automatic sel(input bit [15:0] key, input bit [1:0] sz = 2'd1);
    @(negedge clk); drv(1'b1, sz, key, 1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic rdChk(input int exp, input string tag, input bit [1:0] sz = 2'd0);
    @(negedge clk); drv(1'b0, 2'd1, 16'h0, 1'b1, 1'b0, sz, 8'h00);
    #1 if (sz == 2'd0) chk(tag, dataRdData, exp);
  endtask

  task automatic wrB(input bit [7:0] d, input bit [1:0] sz, input bit expDone,
                     input int bank, input int idx, input string tag);
    @(negedge clk); drv(1'b0, 2'd1, 16'h0, 1'b0, 1'b1, sz, d);
    @(negedge clk); drv(1'b0, 2'd1, 16'h0, 1'b0, 1'b0, 2'd0, 8'h00);
    #1 chk({tag, " done"}, doneValid, expDone);
    if (expDone) begin
      chk({tag, " doneBank"}, doneBank, bank);
      chk({tag, " doneIdx"}, doneIdx, idx);
    end
  endtask

  task automatic preB(input int bank, input int idx, input int off, input int d);
    @(negedge clk); drv(1'b0, 2'd1, 16'h0, 1'b0, 1'b0, 2'd0, 8'h00);
    preByteWr = 1'b1; preBank = 1'(bank); preIdx = 4'(idx); preOff = 6'(off); preData = 8'(d);
  endtask

  task automatic preL(input int bank, input int idx, input int len);
    @(negedge clk); drv(1'b0, 2'd1, 16'h0, 1'b0, 1'b0, 2'd0, 8'h00);
    preLenWr = 1'b1; preBank = 1'(bank); preIdx = 4'(idx); preLen = 7'(len);
  endtask

  function automatic int patByte(int bank, int idx, int off);
    return (bank * 97 + idx * 13 + off * 5 + 1) % 256;
  endfunction

  function automatic int sweepLen(int bank, int idx);
    return (idx * 7 + bank * 11) % 65;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    preBank = 0; preIdx = 0; preOff = 0; preData = 0; preLen = 0;
    drv(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 2'd0, 8'h00);
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 reset byte", dataRdData, 8'h4B);
    chk("R1 reset done", doneValid, 0);

    // R1/R9 signature read without any select, then zero fill
    rdChk(8'h4B, "R1 sig0"); rdChk(8'h43, "R9 sig1");
    rdChk(8'h46, "R9 sig2"); rdChk(8'h47, "R9 sig3");
    rdChk(0, "R5 past end"); rdChk(0, "R5 past end hold");

    // R9 default entries
    sel(16'h0001);
    for (int i = 0; i < 16; i++) rdChk(8'hA0 + i, "R9 ident");
    rdChk(0, "R9 ident end");
    sel(16'h0002); rdChk(8'h04, "R9 cpu lo"); rdChk(8'h00, "R9 cpu hi"); rdChk(0, "R9 cpu end");
    sel(16'h0003); rdChk(8'h10, "R9 max lo"); rdChk(8'h00, "R9 max hi");
    sel(16'h0004);
    for (int i = 0; i < 8; i++) rdChk((64'h0123_4567_89AB_CDEF >> (8 * i)) & 8'hFF, "R9 stamp");
    rdChk(0, "R9 stamp end");
    sel(16'h0005); rdChk(0, "R9 empty entry");

    // R2 reselect clears offset; non-halfword select ignored
    sel(16'h0000); rdChk(8'h4B, "R2 first"); rdChk(8'h43, "R2 second");
    sel(16'h0000); rdChk(8'h4B, "R2 reselect");
    sel(16'h0001, 2'd0); rdChk(8'h43, "R2 byte select ignored");
    sel(16'h0001, 2'd2); rdChk(8'h46, "R2 word select ignored");

    // R11 select wins over simultaneous read
    @(negedge clk); drv(1'b1, 2'd1, 16'h0000, 1'b1, 1'b0, 2'd0, 8'h00);
    rdChk(8'h4B, "R11 select wins");

    // R8 wide reads do not advance
    rdChk(0, "R8 wide read", 2'd1);
    rdChk(0, "R8 wide read", 2'd3);
    rdChk(8'h43, "R8 offset unchanged");

    // R3 invalid index fields in both banks
    for (int f = 16; f < 60; f += 7)
      for (int b = 0; b < 2; b++) begin
        sel(16'((b << 15) | f));
        rdChk(0, "R3 invalid read"); rdChk(0, "R3 invalid read2");
      end
    sel(16'h7FFF); wrB(8'h99, 2'd0, 1'b0, 0, 0, "R3 invalid write");
    rdChk(0, "R3 invalid after write");

    // R10/R4 near-exhaustive preload and readback sweep
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < 16; e++) begin
        preL(b, e, sweepLen(b, e));
        for (int o = 0; o < 64; o++) preB(b, e, o, patByte(b, e, o));
      end
    preL(0, 3, 65); // too long: ignored
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < 16; e++) begin
        sel(16'((b << 15) | e));
        for (int o = 0; o < sweepLen(b, e); o++) rdChk(patByte(b, e, o), "R4 R10 sweep byte");
        rdChk(0, "R5 sweep end");
      end

    // R6/R7 fill bank 1 entry 9 (length 9)
    sel(16'hC009);
    for (int i = 0; i < 9; i++) begin
      wrB(8'(8'h30 + i), 2'd0, i == 8, 1, 9, "R7 fill");
      if (i == 3) wrB(8'hEE, 2'd2, 1'b0, 0, 0, "R8 wide write");
    end
    for (int i = 0; i < 9; i++) rdChk(8'h30 + i, "R6 written byte");
    rdChk(0, "R6 written end");

    // R6 write without write flag ignored
    sel(16'h8009); wrB(8'hEE, 2'd0, 1'b0, 0, 0, "R6 no flag");
    sel(16'h8009); rdChk(8'h30, "R6 no flag unchanged");

    // R6 zero-length entry accepts nothing
    sel(16'h4000); wrB(8'h55, 2'd0, 1'b0, 0, 0, "R6 len0 write");
    rdChk(0, "R6 len0 read");

    // R7 offset wraps to 0 after completion
    preL(0, 5, 2);
    sel(16'h4005);
    wrB(8'hA1, 2'd0, 1'b0, 0, 5, "R7 short 1");
    wrB(8'hB2, 2'd0, 1'b1, 0, 5, "R7 short 2");
    wrB(8'hC3, 2'd0, 1'b0, 0, 5, "R7 rewrite");
    sel(16'h0005); rdChk(8'hC3, "R7 wrapped byte0"); rdChk(8'hB2, "R7 byte1");

    @(negedge clk); drv(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 2'd0, 8'h00);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule